// File: doc/BRIEF.md
# Scratchpad and Wait-State Address Router

This block sits on a processor's data port and steers every access to one of two places: a small scratchpad RAM held inside the block, or an external main memory reached through a request/ready port. The choice rests only on the request address. A single aligned window of the address map belongs to the scratchpad. There is no tag store and no hit or miss logic. Everything outside that window goes out to main memory.

Scratchpad accesses finish in one cycle. Main-memory accesses are stretched by a fixed number of wait states that depends on the access width: one for a halfword transfer and three for a word transfer. Main memory can add further cycles by holding its ready low. The processor sees a one-cycle `cpu_ready` pulse when its access completes. The processor keeps its request and data steady until that pulse arrives, and only one access is in flight at a time.

A 32-bit counter adds up every cycle the router spends busy on an access, including the wait states. This gives a direct measure of memory time for performance studies.

Top module: `spm_router`

## Requirements
- R1: The target is decided from the address alone. Addresses in [SPM_BASE, SPM_BASE+SPM_BYTES) use the scratchpad, and every other address uses main memory, including SPM_BASE-4 and SPM_BASE+SPM_BYTES. Defaults are base 0x0001_0000 and 1024 bytes. The scratchpad word index is (addr-SPM_BASE)>>2.
- R2: A scratchpad access raises `cpu_ready` in the first cycle after the edge that accepts it. For a read, `cpu_rdata` in that cycle holds the stored word.
- R3: A scratchpad write updates byte lane i (bits 8i+7:8i) only where `cpu_be[i]`=1. `mm_req` stays low for the whole scratchpad access, so main memory never sees the write.
- R4: A main-memory access with `cpu_wide`=0 (halfword) has one wait cycle. With `mm_ready` high, `cpu_ready` rises in the second cycle after acceptance.
- R5: A main-memory access with `cpu_wide`=1 (word) has three wait cycles. With `mm_ready` high, `cpu_ready` rises in the fourth cycle after acceptance.
- R6: `mm_req` is high only in the final wait cycle. During that cycle `mm_addr`, `mm_we`, `mm_wdata`, `mm_be` and `mm_wide` carry the accepted request. While `mm_ready` is low, `mm_req` and these fields hold steady, and each low cycle delays `cpu_ready` by one cycle.
- R7: For a main-memory read, the `mm_rdata` value taken at the handshake edge appears on `cpu_rdata` during the ready cycle.
- R8: `cycle_count` rises by one for each cycle from the cycle after acceptance through the ready cycle. That is 1, 2 or 4 cycles per access plus any stall cycles. It does not change while the router is idle.
- R9: `cpu_ready` is a one-cycle pulse. A request seen during the ready cycle is not taken as a new access. A request present in the cycle after ready is accepted at the end of that cycle.
- R10: A synchronous active-high `rst` drives `cpu_ready` and `mm_req` low and clears `cycle_count` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wide | input | 1 | 1 = word access, 0 = halfword access |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte-lane enables for writes |
| cpu_ready | output | 1 | Completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mm_req | output | 1 | Main-memory transfer strobe |
| mm_we | output | 1 | Main-memory write |
| mm_wide | output | 1 | Main-memory access width |
| mm_addr | output | 32 | Main-memory address |
| mm_wdata | output | 32 | Main-memory write data |
| mm_be | output | 4 | Main-memory byte enables |
| mm_ready | input | 1 | Main memory completes the transfer |
| mm_rdata | input | 32 | Main-memory read data |
| cycle_count | output | 32 | Accumulated access cycles |

## Verification
The bench aims first at the window edges. It accesses the last scratchpad word and the words just below and just above the window; an off-by-one compare would send one of these to the wrong target, and the measured latency and the appearance of a main-memory strobe would then be wrong. It issues back-to-back accesses with no idle gap. A router that took the request seen during the ready cycle would repeat an access, so every later latency and the cycle total would drift. It also holds main memory unready for several cycles and writes with partial byte enables. A router that dropped the strobe early, let its fields move, counted stalls wrongly or merged lanes wrongly would return the wrong latency, count or read-back data.

// File: rtl/spm_router_pkg.sv
package spm_router_pkg;

    localparam int RT_AW    = 32;
    localparam int RT_DW    = 32;
    localparam int RT_LANES = RT_DW / 8;
    localparam int RT_LSB   = $clog2(RT_LANES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } rt_state_e;

    typedef enum logic {
        TGT_MAIN = 1'b0,
        TGT_SPM  = 1'b1
    } rt_target_e;

    typedef struct packed {
        logic                we;
        logic                wide;
        logic [RT_AW-1:0]    addr;
        logic [RT_DW-1:0]    wdata;
        logic [RT_LANES-1:0] be;
    } rt_req_t;

    // Window membership: base is aligned to the power-of-two size.
    function automatic logic rt_in_window(input logic [RT_AW-1:0] addr,
                                          input logic [RT_AW-1:0] base,
                                          input int unsigned      bytes);
        logic [RT_AW-1:0] mask;
        mask = ~(RT_AW'(bytes) - RT_AW'(1));
        return (addr & mask) == (base & mask);
    endfunction

    function automatic int unsigned rt_wait_states(input logic        wide,
                                                   input int unsigned w_half,
                                                   input int unsigned w_word);
        return wide ? w_word : w_half;
    endfunction

endpackage

// File: rtl/spm_addr_decode.sv
module spm_addr_decode
    import spm_router_pkg::*;
#(
    parameter logic [RT_AW-1:0] BASE  = 32'h0001_0000,
    parameter int unsigned      BYTES = 1024,
    parameter int               IDX_W = 8
) (
    input  logic [RT_AW-1:0] addr,
    output rt_target_e       tgt,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        tgt = rt_in_window(addr, BASE, BYTES) ? TGT_SPM : TGT_MAIN;
        idx = addr[IDX_W+RT_LSB-1:RT_LSB];
    end
endmodule

// File: rtl/spm_ram.sv
module spm_ram
    import spm_router_pkg::*;
#(
    parameter int WORDS = 256,
    parameter int IDX_W = 8
) (
    input  logic                clk,
    input  logic                en,
    input  logic                we,
    input  logic [RT_LANES-1:0] be,
    input  logic [IDX_W-1:0]    idx,
    input  logic [RT_DW-1:0]    wdata,
    output logic [RT_DW-1:0]    rdata
);
    for (genvar g = 0; g < RT_LANES; g++) begin : g_lane
        logic [7:0] lane_mem [WORDS];
        logic [7:0] lane_q;

        always_ff @(posedge clk) begin
            if (en) begin
                if (we && be[g]) begin
                    lane_mem[idx] <= wdata[8*g +: 8];
                end
                lane_q <= lane_mem[idx];
            end
        end

        assign rdata[8*g +: 8] = lane_q;
    end
endmodule

// File: rtl/rt_cycle_counter.sv
module rt_cycle_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/spm_router.sv
module spm_router
    import spm_router_pkg::*;
#(
    parameter logic [RT_AW-1:0] SPM_BASE   = 32'h0001_0000,
    parameter int unsigned      SPM_BYTES  = 1024,
    parameter int unsigned      HALF_WAITS = 1,
    parameter int unsigned      WORD_WAITS = 3,
    parameter int               CNT_W      = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic                cpu_wide,
    input  logic [RT_AW-1:0]    cpu_addr,
    input  logic [RT_DW-1:0]    cpu_wdata,
    input  logic [RT_LANES-1:0] cpu_be,
    output logic                cpu_ready,
    output logic [RT_DW-1:0]    cpu_rdata,
    output logic                mm_req,
    output logic                mm_we,
    output logic                mm_wide,
    output logic [RT_AW-1:0]    mm_addr,
    output logic [RT_DW-1:0]    mm_wdata,
    output logic [RT_LANES-1:0] mm_be,
    input  logic                mm_ready,
    input  logic [RT_DW-1:0]    mm_rdata,
    output logic [CNT_W-1:0]    cycle_count
);
    localparam int SPM_WORDS = int'(SPM_BYTES) / RT_LANES;
    localparam int IDX_W     = $clog2(SPM_WORDS);
    localparam int WAIT_MAX  = (HALF_WAITS > WORD_WAITS) ? int'(HALF_WAITS) : int'(WORD_WAITS);
    localparam int WCNT_W    = (WAIT_MAX < 2) ? 1 : $clog2(WAIT_MAX + 1);

    rt_state_e          state_q;
    rt_target_e         tgt_q;
    rt_target_e         dec_tgt;
    rt_req_t            req_q;
    rt_req_t            req_in;
    logic [IDX_W-1:0]   dec_idx;
    logic [WCNT_W-1:0]  wcnt_q;
    logic [RT_DW-1:0]   mm_data_q;
    logic [RT_DW-1:0]   spm_rdata;
    logic               accept;
    logic               spm_en;
    logic               busy;

    assign req_in = '{we: cpu_we, wide: cpu_wide, addr: cpu_addr,
                      wdata: cpu_wdata, be: cpu_be};

    spm_addr_decode #(
        .BASE  (SPM_BASE),
        .BYTES (SPM_BYTES),
        .IDX_W (IDX_W)
    ) u_decode (
        .addr (cpu_addr),
        .tgt  (dec_tgt),
        .idx  (dec_idx)
    );

    assign accept = (state_q == ST_IDLE) && cpu_req;
    assign spm_en = accept && (dec_tgt == TGT_SPM);

    spm_ram #(
        .WORDS (SPM_WORDS),
        .IDX_W (IDX_W)
    ) u_ram (
        .clk   (clk),
        .en    (spm_en),
        .we    (cpu_we),
        .be    (cpu_be),
        .idx   (dec_idx),
        .wdata (cpu_wdata),
        .rdata (spm_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            tgt_q     <= TGT_MAIN;
            req_q     <= '0;
            wcnt_q    <= '0;
            mm_data_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        req_q <= req_in;
                        tgt_q <= dec_tgt;
                        if (dec_tgt == TGT_SPM) begin
                            state_q <= ST_RESP;
                        end else begin
                            state_q <= ST_WAIT;
                            wcnt_q  <= WCNT_W'(rt_wait_states(cpu_wide, HALF_WAITS, WORD_WAITS) - 1);
                        end
                    end
                end
                ST_WAIT: begin
                    if (wcnt_q != '0) begin
                        wcnt_q <= wcnt_q - WCNT_W'(1);
                    end else if (mm_ready) begin
                        mm_data_q <= mm_rdata;
                        state_q   <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);

    rt_cycle_counter #(
        .W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst   (rst),
        .inc   (busy),
        .count (cycle_count)
    );

    always_comb begin
        cpu_ready = (state_q == ST_RESP);
        cpu_rdata = (tgt_q == TGT_SPM) ? spm_rdata : mm_data_q;
        mm_req    = (state_q == ST_WAIT) && (wcnt_q == '0);
        mm_we     = req_q.we;
        mm_wide   = req_q.wide;
        mm_addr   = req_q.addr;
        mm_wdata  = req_q.wdata;
        mm_be     = req_q.be;
    end

endmodule

// File: rtl/spm_router_chk.sv
module spm_router_chk
    import spm_router_pkg::*;
#(
    parameter logic [RT_AW-1:0] SPM_BASE  = 32'h0001_0000,
    parameter int unsigned      SPM_BYTES = 1024,
    parameter int               CNT_W     = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_req,
    input logic             cpu_wide,
    input logic [RT_AW-1:0] cpu_addr,
    input logic             cpu_ready,
    input logic             mm_req,
    input logic             mm_ready,
    input logic [RT_AW-1:0] mm_addr,
    input logic [CNT_W-1:0] cycle_count,
    input rt_state_e        state
);
    logic take_spm, take_mm_half, take_mm_word;

    assign take_spm     = (state == ST_IDLE) && cpu_req &&  rt_in_window(cpu_addr, SPM_BASE, SPM_BYTES);
    assign take_mm_half = (state == ST_IDLE) && cpu_req && !rt_in_window(cpu_addr, SPM_BASE, SPM_BYTES) && !cpu_wide;
    assign take_mm_word = (state == ST_IDLE) && cpu_req && !rt_in_window(cpu_addr, SPM_BASE, SPM_BYTES) &&  cpu_wide;

    a_r2_spm_one_cycle: assert property (@(posedge clk) disable iff (rst)
        take_spm |=> cpu_ready);

    a_r3_spm_no_main: assert property (@(posedge clk) disable iff (rst)
        take_spm |=> !mm_req);

    a_r4_half_wait: assert property (@(posedge clk) disable iff (rst)
        take_mm_half |=> !cpu_ready);

    a_r5_word_wait: assert property (@(posedge clk) disable iff (rst)
        take_mm_word |=> !cpu_ready ##1 !cpu_ready ##1 !cpu_ready);

    a_r6_strobe_hold: assert property (@(posedge clk) disable iff (rst)
        (mm_req && !mm_ready) |=> (mm_req && $stable(mm_addr)));

    a_r8_count_busy: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> (cycle_count == $past(cycle_count) + CNT_W'(1)));

    a_r8_count_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> $stable(cycle_count));

    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (!cpu_ready && !mm_req && cycle_count == '0));

endmodule

bind spm_router spm_router_chk #(
    .SPM_BASE  (SPM_BASE),
    .SPM_BYTES (SPM_BYTES),
    .CNT_W     (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_req     (cpu_req),
    .cpu_wide    (cpu_wide),
    .cpu_addr    (cpu_addr),
    .cpu_ready   (cpu_ready),
    .mm_req      (mm_req),
    .mm_ready    (mm_ready),
    .mm_addr     (mm_addr),
    .cycle_count (cycle_count),
    .state       (state_q)
);

// File: tb/spm_router_test.sv
module spm_router_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE  = 32'h0001_0000;
    localparam int          BYTES = 1024;
    localparam int          WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_wide = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mm_req, mm_we, mm_wide, mm_ready;
    logic [31:0] mm_addr, mm_wdata, mm_rdata;
    logic [3:0]  mm_be;
    logic [31:0] cycle_count;

    spm_router uut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wide(cpu_wide),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mm_req(mm_req), .mm_we(mm_we), .mm_wide(mm_wide), .mm_addr(mm_addr),
        .mm_wdata(mm_wdata), .mm_be(mm_be), .mm_ready(mm_ready), .mm_rdata(mm_rdata),
        .cycle_count(cycle_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Main-memory model: 64 words, stalls stall_cfg cycles per strobe.
    logic [31:0] mm_mem [64];
    int          stall_cfg = 0;
    int          stall_seen;

    assign mm_ready = (stall_seen >= stall_cfg);
    assign mm_rdata = mm_mem[mm_addr[7:2]];

    always @(posedge clk) begin
        if (rst) begin
            stall_seen <= 0;
            for (int i = 0; i < 64; i++) mm_mem[i] <= 32'hA500_0000 | i;
        end else begin
            if (!mm_req) stall_seen <= 0;
            else if (!mm_ready) stall_seen <= stall_seen + 1;
            if (mm_req && mm_ready && mm_we) begin
                for (int b = 0; b < 4; b++)
                    if (mm_be[b]) mm_mem[mm_addr[7:2]][8*b +: 8] <= mm_wdata[8*b +: 8];
            end
        end
    end

    // Reference models.
    logic [31:0] ref_spm [256];
    logic [31:0] ref_mm  [64];

    typedef struct {
        int          lat;
        bit          is_spm;
        bit          rd;
        logic [31:0] data;
        logic [31:0] addr;
        bit          we;
        int          strobes;
        string       tag;
    } item_t;

    item_t scb[$];
    int    exp_total = 0;

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be);
        logic [31:0] r;
        r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic access(input bit we, input bit wide, input logic [31:0] addr,
                          input logic [31:0] wdata, input logic [3:0] be,
                          input int stall, input string tag);
        item_t it;
        bit    spm;
        int    si, mi;
        spm = (addr >= BASE) && (addr < BASE + BYTES);
        si  = int'((addr - BASE) >> 2) & 255;
        mi  = int'(addr[7:2]);
        it.is_spm  = spm;
        it.lat     = spm ? 1 : ((wide ? 4 : 2) + stall);
        it.rd      = !we;
        it.addr    = addr;
        it.we      = we;
        it.strobes = spm ? 0 : 1 + stall;
        it.tag     = tag;
        it.data    = spm ? ref_spm[si] : ref_mm[mi];
        if (we) begin
            if (spm) ref_spm[si] = merge(ref_spm[si], wdata, be);
            else     ref_mm[mi]  = merge(ref_mm[mi], wdata, be);
        end
        scb.push_back(it);
        stall_cfg = stall;
        cpu_we    = we;
        cpu_wide  = wide;
        cpu_addr  = addr;
        cpu_wdata = wdata;
        cpu_be    = be;
        cpu_req   = 1'b1;
        do @(negedge clk); while (!cpu_ready);
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
    endtask

    // Monitor: measures latency and strobes, compares against the queue.
    int lat_cnt = 0;
    int strobe_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mm_req) begin
                strobe_cnt++;
                if (mm_ready && scb.size() != 0) begin
                    chk(mm_addr == scb[0].addr, "R6", "strobe address", mm_addr, scb[0].addr);
                    chk(mm_we == scb[0].we, "R6", "strobe direction", 32'(mm_we), 32'(scb[0].we));
                end
            end
            if (cpu_req && !cpu_ready) lat_cnt++;
            if (cpu_ready) begin
                if (scb.size() == 0) begin
                    chk(1'b0, "R9", "ready with no access pending", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = scb.pop_front();
                    chk(lat_cnt == it.lat, it.tag, "latency", 32'(lat_cnt), 32'(it.lat));
                    if (it.is_spm)
                        chk(strobe_cnt == 0, "R3", "main strobes during scratchpad access",
                            32'(strobe_cnt), 32'd0);
                    else
                        chk(strobe_cnt == it.strobes, "R6", "strobe cycles",
                            32'(strobe_cnt), 32'(it.strobes));
                    if (it.rd)
                        chk(cpu_rdata == it.data, it.is_spm ? "R2" : "R7", "read data",
                            cpu_rdata, it.data);
                    chk(cycle_count == 32'(exp_total + it.lat - 1), "R8", "cycle count at ready",
                        cycle_count, 32'(exp_total + it.lat - 1));
                    exp_total += it.lat;
                end
                lat_cnt    = 0;
                strobe_cnt = 0;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog expired: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_mm[i] = 32'hA500_0000 | i;
        for (int i = 0; i < 256; i++) ref_spm[i] = '0;

        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R10", "ready in reset", 32'(cpu_ready), 32'd0);
        chk(mm_req == 1'b0, "R10", "strobe in reset", 32'(mm_req), 32'd0);
        chk(cycle_count == 32'd0, "R10", "count in reset", cycle_count, 32'd0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(posedge clk);
        #1;

        // Scratchpad: full word and byte-lane writes, boundary words (R1, R2, R3).
        access(1, 1, BASE,             32'hDEAD_BEEF, 4'hF, 0, "R1");
        access(0, 1, BASE,             32'h0,         4'hF, 0, "R2");
        access(1, 1, BASE + BYTES - 4, 32'h1122_3344, 4'hF, 0, "R1");
        access(1, 0, BASE + BYTES - 4, 32'hAABB_CCDD, 4'b0101, 0, "R3");
        access(0, 0, BASE + BYTES - 4, 32'h0,         4'hF, 0, "R2");

        // Just outside the window on either side (R1, R4, R5, R7).
        access(0, 0, BASE - 4,     32'h0, 4'hF, 0, "R4");
        access(0, 1, BASE + BYTES, 32'h0, 4'hF, 0, "R5");

        // Scratchpad write must not reach main memory word 2 (R3).
        access(1, 1, BASE + 8, 32'h5555_AAAA, 4'hF, 0, "R2");
        access(0, 1, 32'h0000_0008, 32'h0, 4'hF, 0, "R5");

        // Main-memory partial write then narrow read (R6, R7).
        access(1, 1, 32'h0000_0100, 32'h1234_5678, 4'b1100, 0, "R5");
        access(0, 0, 32'h0000_0100, 32'h0, 4'hF, 0, "R4");

        // Stalled main memory (R6).
        access(0, 1, 32'h0000_0020, 32'h0, 4'hF, 2, "R6");
        access(1, 0, 32'h0000_0024, 32'hCAFE_F00D, 4'hF, 1, "R6");
        access(0, 1, 32'h0000_0024, 32'h0, 4'hF, 0, "R7");

        // Back-to-back mixed traffic, no idle gap between accesses (R9).
        for (int i = 0; i < 6; i++) begin
            access(1, 1, BASE + 32'(16 + 4*i), 32'h0101_0101 * i, 4'hF, 0, "R9");
            access(0, (i % 2) == 1, 32'h0000_0040 + 32'(4*i), 32'h0, 4'hF, i % 3, "R9");
            access(0, 1, BASE + 32'(16 + 4*i), 32'h0, 4'hF, 0, "R9");
        end

        // Idle: count holds (R8).
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(scb.size() == 0, "R9", "pending accesses at end", 32'(scb.size()), 32'd0);
        chk(cycle_count == 32'(exp_total), "R8", "final cycle total", cycle_count, 32'(exp_total));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule